// File: doc/BRIEF.md
# SDR SDRAM Device Model

This block stands in for a single-data-rate SDRAM chip on the pin side of a memory controller. It is synthesizable, so it can be used in a self-checking testbench or in an emulation build. Every rising clock edge it samples the command pins, bank select, address, byte masks and write data. It decodes the command and keeps one open-row record per bank. Data is held in a small byte-lane array sized by parameters. Read data comes back on a separate output after the programmed CAS latency.

Protocol misuse by the controller is never fatal. Each class of misuse sets its own sticky flag. A bench can read the flag vector at any time, or once at the end of a run, to find out whether the controller broke a rule. Refresh is accepted and ignored. Bursts longer than one beat, auto-precharge and electrical timing are not modelled.

Top module: `sdram_dev_model`

## Requirements
- R1: A command is accepted only on an edge where `cs_n` is 0 and `cke` was 1 at the previous rising edge. A rejected command changes no bank state, no stored data and no flag.
- R2: The command code is {`ras_n`,`cas_n`,`we_n`}. The codes are: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 111 no-op. Refresh and no-op have no effect. Code 110 sets `err_flags[0]`.
- R3: A mode set is applied only when `ba` is 0 and `addr[10]` is 0, and it loads the CAS latency from `addr[6:4]`. After reset the CAS latency is 2.
- R4: An applied mode set with any of `addr` bits 3, 7, 8 or 9 high sets `err_flags[1]`.
- R5: A precharge with `addr[10]`=1 closes every bank. With `addr[10]`=0 it closes only bank `ba`.
- R6: An activate opens bank `ba` on row `addr[ROW_W-1:0]`. Activating a bank that is already open sets `err_flags[2]`.
- R7: A write to an open bank stores each byte lane i (bits 8i+7:8i) whose `dqm[i]` is 0. Lanes with `dqm[i]`=1 keep their old contents.
- R8: A write with `addr[10]`=1 sets `err_flags[3]`. A write with `dq_drive`=0 sets `err_flags[4]`.
- R9: A read loads the addressed word. With CAS latency L of 2 or 3, `dq_out` takes that word at the (L-1)-th rising edge after the command edge and holds it until the pipeline next advances.
- R10: While the CAS latency is neither 2 nor 3, `dq_out` does not change.
- R11: A read with `addr[10]`=1 or with `dq_drive`=1 sets `err_flags[5]`.
- R12: A read or write to a closed bank sets `err_flags[6]`. A write to a closed bank stores nothing.
- R13: The word address is {bank, open row, `addr[COL_W-1:0]`}. Address bits above COL_W do not affect the column, and row bits above ROW_W do not affect the row.
- R14: Reset closes all banks, clears `dq_out` and all flags, and sets the CAS latency to 2. Flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable, gates the command of the following edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, command code bit 2 |
| cas_n | input | 1 | Column strobe, command code bit 1 |
| we_n | input | 1 | Write strobe, command code bit 0 |
| ba | input | $clog2(BANKS) | Bank select |
| addr | input | ADDR_W | Row, column or mode address; bit 10 is the all-banks / auto-precharge flag |
| dqm | input | BYTES | Per-lane write mask, 1 = lane not written |
| dq_in | input | 8*BYTES | Write data from the controller |
| dq_drive | input | 1 | High while the controller drives the data bus |
| dq_out | output | 8*BYTES | Read data returned to the controller |
| err_flags | output | 7 | Sticky misuse flags, bit assignment as in R2, R4, R6, R8, R11, R12 |

## Verification
Flags, bank state and stored data are updated at the command edge itself. The bench therefore samples them at the falling edge right after that edge. Read data arrives L-1 edges after the read's edge, so the bench waits L-1 further falling edges before comparing `dq_out`. For latency 3 it also checks that the old value is still present one falling edge earlier. For an unsupported latency it checks that the output stays frozen over several edges. Bank state is not visible at the ports, so opening and closing are judged through the activate-conflict and closed-access flags. Ignored commands are judged through a read-back.

// File: rtl/sdram_model_pkg.sv
package sdram_model_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  localparam int ERR_W       = 7;
  localparam int ERR_UNKNOWN = 0;
  localparam int ERR_MODE    = 1;
  localparam int ERR_ACTOPEN = 2;
  localparam int ERR_WR_AP   = 3;
  localparam int ERR_WR_DIR  = 4;
  localparam int ERR_RD      = 5;
  localparam int ERR_CLOSED  = 6;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_model_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic cmd_en,
  output cmd_e cmd
);

  logic cke_q;
  logic cke_d;

  always_comb begin
    cke_d = cke;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke_d;
  end

  assign cmd_en = !cs_n && cke_q;
  assign cmd    = cmd_e'({ras_n, cas_n, we_n});

  // R1: an accepted command always follows an edge with cke high
  a_r1_cke_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_en |-> $past(cke));

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_model_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROW_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_en,
  input  cmd_e                     cmd,
  input  logic [$clog2(BANKS)-1:0] ba,
  input  logic [ROW_W-1:0]         row_in,
  input  logic                     all_banks,
  output logic [BANKS-1:0]         open_q,
  output logic                     sel_open,
  output logic [ROW_W-1:0]         sel_row,
  output logic                     act_conflict
);

  localparam int BA_W = $clog2(BANKS);

  logic [ROW_W-1:0] rows_all [BANKS];
  logic             is_act;
  logic             is_pre;

  assign is_act = cmd_en && (cmd == CMD_ACT);
  assign is_pre = cmd_en && (cmd == CMD_PRE);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             hit;
    logic             open_r;
    logic             open_d;
    logic [ROW_W-1:0] row_r;
    logic             row_en;

    assign hit = (ba == BA_W'(b));

    always_comb begin
      open_d = open_r;
      row_en = 1'b0;
      if (is_act && hit) begin
        open_d = 1'b1;
        row_en = 1'b1;
      end else if (is_pre && (all_banks || hit)) begin
        open_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_r <= 1'b0;
      else        open_r <= open_d;
    end

    always_ff @(posedge clk) begin
      if (row_en) row_r <= row_in;
    end

    assign open_q[b]   = open_r;
    assign rows_all[b] = row_r;
  end

  assign sel_open     = open_q[ba];
  assign sel_row      = rows_all[ba];
  assign act_conflict = is_act && open_q[ba];

  // R1: with no accepted command the bank state holds
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_en |=> $stable(open_q));

  // R5: precharge with the all-banks flag leaves every bank closed
  a_r5_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && all_banks) |=> (open_q == '0));

  // R6: the activated bank is open on the next cycle
  a_r6_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> open_q[$past(ba)]);

endmodule

// File: rtl/sdram_store.sv
module sdram_store #(
  parameter int BYTES = 2,
  parameter int IDX_W = 10
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [BYTES-1:0]   lane_en,
  input  logic [IDX_W-1:0]   idx,
  input  logic [BYTES*8-1:0] wdata,
  output logic [BYTES*8-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  for (genvar l = 0; l < BYTES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && lane_en[l]) mem[idx] <= wdata[l*8 +: 8];
    end

    assign rdata[l*8 +: 8] = mem[idx];
  end

endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ld,
  input  logic [2:0]    cl_new,
  input  logic          rd_ld,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] dq_out
);

  localparam logic [2:0] CL_RESET = 3'd2;

  logic [2:0]    cl_q,  cl_d;
  logic [DW-1:0] st0_q, st0_d;
  logic [DW-1:0] st1_q, st1_d;
  logic [DW-1:0] st2_q, st2_d;
  logic [DW-1:0] dq_q,  dq_d;
  logic          run;

  assign run = (cl_q == 3'd2) || (cl_q == 3'd3);

  always_comb begin
    cl_d  = mode_ld ? cl_new : cl_q;
    st0_d = rd_ld ? rd_word : st0_q;
    st1_d = st1_q;
    st2_d = st2_q;
    dq_d  = dq_q;
    if (run) begin
      st1_d = st0_d;
      st2_d = st1_q;
      dq_d  = (cl_q == 3'd2) ? st1_q : st2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q  <= CL_RESET;
      st0_q <= '0;
      st1_q <= '0;
      st2_q <= '0;
      dq_q  <= '0;
    end else begin
      cl_q  <= cl_d;
      st0_q <= st0_d;
      st1_q <= st1_d;
      st2_q <= st2_d;
      dq_q  <= dq_d;
    end
  end

  assign dq_out = dq_q;

  // R9: at latency 2 the word read appears two sampling points later
  a_r9_cl2_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ld && cl_q == 3'd2) |-> ##2 (dq_out == $past(rd_word, 2)));

  // R10: unsupported latency freezes the output
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(dq_out));

  // R3: an applied mode set loads the new latency
  a_r3_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ld |=> (cl_q == $past(cl_new)));

endmodule

// File: rtl/sdram_dev_model.sv
module sdram_dev_model
  import sdram_model_pkg::*;
#(
  parameter int BYTES  = 2,
  parameter int BANKS  = 4,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 5,
  parameter int ADDR_W = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke,
  input  logic                     cs_n,
  input  logic                     ras_n,
  input  logic                     cas_n,
  input  logic                     we_n,
  input  logic [$clog2(BANKS)-1:0] ba,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BYTES-1:0]         dqm,
  input  logic [BYTES*8-1:0]       dq_in,
  input  logic                     dq_drive,
  output logic [BYTES*8-1:0]       dq_out,
  output logic [ERR_W-1:0]         err_flags
);

  localparam int                BA_W      = $clog2(BANKS);
  localparam int                DW        = BYTES * 8;
  localparam int                IDX_W     = BA_W + ROW_W + COL_W;
  localparam int                FLAG_BIT  = 10;
  localparam logic [ADDR_W-1:0] MODE_MASK = ADDR_W'(11'h388);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic cmd_en;
  cmd_e cmd;

  sdram_cmd_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .cke    (cke),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .cmd_en (cmd_en),
    .cmd    (cmd)
  );

  logic [BANKS-1:0] open_q;
  logic             sel_open;
  logic [ROW_W-1:0] sel_row;
  logic             act_conflict;
  logic             flag10;

  assign flag10 = addr[FLAG_BIT];

  sdram_bank_track #(
    .BANKS (BANKS),
    .ROW_W (ROW_W)
  ) u_banks (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .cmd_en       (cmd_en),
    .cmd          (cmd),
    .ba           (ba),
    .row_in       (addr[ROW_W-1:0]),
    .all_banks    (flag10),
    .open_q       (open_q),
    .sel_open     (sel_open),
    .sel_row      (sel_row),
    .act_conflict (act_conflict)
  );

  logic             is_wr, is_rd, is_mrs, is_bad;
  logic             mode_apply, wr_go;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    rd_word;

  assign is_wr      = cmd_en && (cmd == CMD_WR);
  assign is_rd      = cmd_en && (cmd == CMD_RD);
  assign is_mrs     = cmd_en && (cmd == CMD_MRS);
  assign is_bad     = cmd_en && (cmd == CMD_BST);
  assign mode_apply = is_mrs && (ba == '0) && !flag10;
  assign wr_go      = is_wr && sel_open;
  assign idx        = {ba, sel_row, addr[COL_W-1:0]};

  sdram_store #(
    .BYTES (BYTES),
    .IDX_W (IDX_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_go),
    .lane_en (~dqm),
    .idx     (idx),
    .wdata   (dq_in),
    .rdata   (rd_word)
  );

  sdram_read_pipe #(
    .DW (DW)
  ) u_rpipe (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .mode_ld (mode_apply),
    .cl_new  (addr[6:4]),
    .rd_ld   (is_rd),
    .rd_word (rd_word),
    .dq_out  (dq_out)
  );

  // sticky misuse flags
  logic [ERR_W-1:0] err_q, err_d, err_set;

  always_comb begin
    err_set              = '0;
    err_set[ERR_UNKNOWN] = is_bad;
    err_set[ERR_MODE]    = mode_apply && ((addr & MODE_MASK) != '0);
    err_set[ERR_ACTOPEN] = act_conflict;
    err_set[ERR_WR_AP]   = is_wr && flag10;
    err_set[ERR_WR_DIR]  = is_wr && !dq_drive;
    err_set[ERR_RD]      = is_rd && (flag10 || dq_drive);
    err_set[ERR_CLOSED]  = (is_wr || is_rd) && !sel_open;
    err_d                = err_q | err_set;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) err_q <= '0;
    else             err_q <= err_d;
  end

  assign err_flags = err_q;

  // R14: a flag once set never clears before reset
  a_r14_sticky: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((err_q & $past(err_q)) == $past(err_q)));

  // R12: a write to a closed bank is flagged on the next cycle
  a_r12_closed_wr: assert property (@(posedge clk) disable iff (!rst_core_n)
    (is_wr && !sel_open) |=> err_flags[ERR_CLOSED]);

endmodule

// File: tb/test_sdram_dev_model.sv
module test_sdram_dev_model;

  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010,
                         C_ACT = 3'b011, C_WR  = 3'b100, C_RD  = 3'b101,
                         C_BAD = 3'b110, C_NOP = 3'b111;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n, dq_drive;
  logic [1:0]  ba, dqm;
  logic [10:0] addr;
  logic [15:0] dq_in, dq_out;
  logic [6:0]  err_flags;

  always #4 clk = ~clk;

  sdram_dev_model i_sdram_dev_model (
    .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr), .dqm (dqm),
    .dq_in (dq_in), .dq_drive (dq_drive), .dq_out (dq_out),
    .err_flags (err_flags)
  );

  int          nchk = 0;
  int          nerr = 0;
  bit          done = 0;
  int          cur_cl = 2;
  logic [15:0] ref_mem [128];
  logic [6:0]  exp_err = '0;

  function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] n,
                                        input logic [1:0] m);
    merge = o;
    if (!m[0]) merge[7:0]  = n[7:0];
    if (!m[1]) merge[15:8] = n[15:8];
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_err(input string tag);
    check(tag, {9'd0, err_flags}, {9'd0, exp_err});
  endtask

  task automatic drive(input logic cs, input logic [2:0] code, input logic [1:0] b,
                       input logic [10:0] a, input logic [1:0] m,
                       input logic [15:0] d, input logic oe);
    @(negedge clk);
    cs_n = cs; {ras_n, cas_n, we_n} = code; ba = b; addr = a; dqm = m;
    dq_in = d; dq_drive = oe;
    @(negedge clk);
    cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP; dq_drive = 1'b0;
  endtask

  task automatic wr(input logic [1:0] b, input logic [4:0] c, input logic [15:0] d,
                    input logic [1:0] m);
    drive(1'b0, C_WR, b, {6'd0, c}, m, d, 1'b1);
    ref_mem[{b, c}] = merge(ref_mem[{b, c}], d, m);
  endtask

  task automatic rd_check(input logic [1:0] b, input logic [4:0] c, input string tag);
    drive(1'b0, C_RD, b, {6'd0, c}, 2'b00, 16'h0, 1'b0);
    repeat (cur_cl - 1) @(negedge clk);
    check(tag, dq_out, ref_mem[{b, c}]);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [15:0] prev;
    void'($urandom(32'd1234));
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP;
    ba = 0; addr = 0; dqm = 0; dq_in = 0; dq_drive = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R14 reset dq_out", dq_out, 16'h0);
    check_err("R14 reset flags");

    // open one row per bank; bank 2 row given with high bits set (R13)
    drive(1'b0, C_ACT, 2'd0, 11'd3,    2'b00, 16'h0, 1'b0);
    drive(1'b0, C_ACT, 2'd1, 11'd5,    2'b00, 16'h0, 1'b0);
    drive(1'b0, C_ACT, 2'd2, 11'h7F9,  2'b00, 16'h0, 1'b0);
    drive(1'b0, C_ACT, 2'd3, 11'd6,    2'b00, 16'h0, 1'b0);
    check_err("R6 activates of closed banks raise nothing");

    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 32; c++)
        wr(b[1:0], c[4:0], 16'($urandom), 2'b00);
    check_err("R7 full writes raise nothing");
    rd_check(2'd2, 5'd5, "R9 CL2 read bank2");
    rd_check(2'd0, 5'd31, "R13 read last column");

    // column bits above COL_W ignored (R13)
    drive(1'b0, C_WR, 2'd1, 11'h3E7, 2'b00, 16'hBEEF, 1'b1);
    ref_mem[{2'd1, 5'd7}] = 16'hBEEF;
    rd_check(2'd1, 5'd7, "R13 high column bits ignored");

    // byte lanes (R7)
    wr(2'd0, 5'd4, 16'h1234, 2'b00);
    wr(2'd0, 5'd4, 16'hA1B2, 2'b01);
    wr(2'd0, 5'd4, 16'hFFFF, 2'b11);
    rd_check(2'd0, 5'd4, "R7 masked lanes kept");

    // refresh has no effect (R2)
    drive(1'b0, C_REF, 2'd0, 11'h400, 2'b00, 16'h0, 1'b0);
    check_err("R2 refresh no flag");
    rd_check(2'd0, 5'd4, "R2 refresh leaves data");

    // gating (R1)
    drive(1'b1, C_ACT, 2'd0, 11'd3, 2'b00, 16'h0, 1'b0);
    check_err("R1 cs_n high activate ignored");
    drive(1'b1, C_WR, 2'd1, 11'd9, 2'b00, 16'h5555, 1'b1);
    rd_check(2'd1, 5'd9, "R1 cs_n high write ignored");
    @(negedge clk); cke = 1'b0;
    drive(1'b0, C_ACT, 2'd0, 11'd3, 2'b00, 16'h0, 1'b0);
    check_err("R1 cke low activate ignored");
    drive(1'b0, C_WR, 2'd1, 11'd9, 2'b00, 16'h6666, 1'b1);
    cke = 1'b1;
    rd_check(2'd1, 5'd9, "R1 cke low write ignored");

    // precharge one bank then all (R5)
    drive(1'b0, C_PRE, 2'd2, 11'h000, 2'b00, 16'h0, 1'b0);
    drive(1'b0, C_ACT, 2'd2, 11'd1, 2'b00, 16'h0, 1'b0);
    check_err("R5 single precharge closed bank2");
    rd_check(2'd3, 5'd2, "R5 bank3 stayed open");
    check_err("R5 bank3 access not flagged");
    drive(1'b0, C_PRE, 2'd0, 11'h400, 2'b00, 16'h0, 1'b0);
    drive(1'b0, C_ACT, 2'd0, 11'd3, 2'b00, 16'h0, 1'b0);
    drive(1'b0, C_ACT, 2'd1, 11'd5, 2'b00, 16'h0, 1'b0);
    drive(1'b0, C_ACT, 2'd2, 11'd1, 2'b00, 16'h0, 1'b0);
    drive(1'b0, C_ACT, 2'd3, 11'd6, 2'b00, 16'h0, 1'b0);
    check_err("R5 precharge all closed every bank");
    rd_check(2'd2, 5'd5, "R13 reopened row keeps data");

    // random traffic
    for (int i = 0; i < 60; i++) begin
      logic [1:0] b, b2, m;
      logic [4:0] c, c2;
      b = 2'($urandom); c = 5'($urandom); m = 2'($urandom);
      wr(b, c, 16'($urandom), m);
      b2 = 2'($urandom); c2 = 5'($urandom);
      if (i % 4 == 0) begin b2 = b; c2 = c; end
      rd_check(b2, c2, "R7 R9 random read-back");
    end
    check_err("R7 random traffic raises nothing");

    // mode set (R3, R4, R9)
    drive(1'b0, C_MRS, 2'd1, 11'h3B0, 2'b00, 16'h0, 1'b0);
    drive(1'b0, C_MRS, 2'd0, 11'h430, 2'b00, 16'h0, 1'b0);
    check_err("R4 ignored mode sets raise no warning");
    wr(2'd3, 5'd11, 16'h5A5A, 2'b00);
    rd_check(2'd3, 5'd11, "R3 ignored mode sets keep CL2");
    drive(1'b0, C_MRS, 2'd0, 11'h030, 2'b00, 16'h0, 1'b0);
    cur_cl = 3;
    wr(2'd3, 5'd10, 16'h3C3C, 2'b00);
    drive(1'b0, C_RD, 2'd3, 11'd10, 2'b00, 16'h0, 1'b0);
    @(negedge clk);
    check("R9 CL3 not yet", dq_out, 16'h5A5A);
    @(negedge clk);
    check("R9 CL3 data", dq_out, 16'h3C3C);
    check_err("R4 clean mode set no warning");

    drive(1'b0, C_MRS, 2'd0, 11'h040, 2'b00, 16'h0, 1'b0);
    wr(2'd3, 5'd12, 16'h9696, 2'b00);
    drive(1'b0, C_RD, 2'd3, 11'd12, 2'b00, 16'h0, 1'b0);
    prev = dq_out;
    check("R10 frozen at read", dq_out, 16'h3C3C);
    repeat (4) @(negedge clk);
    check("R10 frozen after 4 edges", dq_out, prev);

    drive(1'b0, C_MRS, 2'd0, 11'h028, 2'b00, 16'h0, 1'b0);
    cur_cl = 2;
    exp_err[1] = 1'b1;
    check_err("R4 mask bit sets warning");
    rd_check(2'd3, 5'd11, "R3 back to CL2");

    drive(1'b0, C_BAD, 2'd0, 11'h0, 2'b00, 16'h0, 1'b0);
    exp_err[0] = 1'b1;
    check_err("R2 code 110 flagged");

    drive(1'b0, C_WR, 2'd0, 11'h401, 2'b00, 16'h0101, 1'b1);
    ref_mem[{2'd0, 5'd1}] = 16'h0101;
    exp_err[3] = 1'b1;
    check_err("R8 write auto-precharge flagged");
    drive(1'b0, C_WR, 2'd0, 11'h002, 2'b00, 16'h0202, 1'b0);
    ref_mem[{2'd0, 5'd2}] = 16'h0202;
    exp_err[4] = 1'b1;
    check_err("R8 write direction flagged");
    drive(1'b0, C_RD, 2'd0, 11'h401, 2'b00, 16'h0, 1'b0);
    exp_err[5] = 1'b1;
    check_err("R11 read auto-precharge flagged");

    drive(1'b0, C_ACT, 2'd0, 11'd3, 2'b00, 16'h0, 1'b0);
    exp_err[2] = 1'b1;
    check_err("R6 activate of open bank flagged");

    drive(1'b0, C_PRE, 2'd0, 11'h400, 2'b00, 16'h0, 1'b0);
    drive(1'b0, C_WR, 2'd0, 11'd4, 2'b00, 16'hDEAD, 1'b1);
    exp_err[6] = 1'b1;
    check_err("R12 closed bank write flagged");
    drive(1'b0, C_ACT, 2'd0, 11'd3, 2'b00, 16'h0, 1'b0);
    rd_check(2'd0, 5'd4, "R12 closed bank write stored nothing");
    rd_check(2'd0, 5'd1, "R8 flagged write still stored");
    repeat (3) @(negedge clk);
    check_err("R14 flags sticky");

    finish_run();
  end

endmodule